// File: doc/BRIEF.md
# Exclusive Reservation Monitor

This block sits between several processors and one shared byte memory and gives them load-exclusive and store-exclusive operations. A load-exclusive reads a byte and books its containing aligned 32-bit word for the issuing processor. A later store-exclusive from that processor writes memory only if the booking is still intact. It reports 0 when the write was done and 1 when it was refused, and the caller then retries. Addresses on the ports are already physical, so two virtual mappings of one location meet on the same reservation.

Each processor holds one local reservation. An uncached load-exclusive also records an entry in a global table indexed by processor number. Bookings are lost in five cases: any store-exclusive by the owner, a clear command, an interrupt or context-switch pulse, a committed write to the word by another processor, and a newer load-exclusive. Each processor gets one request port. All requests of a cycle are judged against the reservation state at the start of that cycle. Responses appear one cycle later.

Top module: `excl_monitor`

## Requirements
- R1: Request kinds are encoded 0 load, 1 store, 2 load-exclusive, 3 store-exclusive. A load or load-exclusive returns the addressed byte on its response one cycle later, and a load-exclusive books the word `addr[AW-1:2]` for its processor.
- R2: A store-exclusive to any byte of the word its processor has booked writes its byte and returns status 0.
- R3: A store-exclusive without a booking on its word returns status 1 and leaves memory unchanged.
- R4: Every store-exclusive consumes its processor's booking, whether it succeeds or not, so a second one fails.
- R5: A clear pulse drops the processor's booking and accesses no memory.
- R6: An interrupt/context-switch pulse drops the processor's bookings, so a following store-exclusive fails.
- R7: A committed write by another processor to a booked word cancels that booking. The owner's own plain store does not cancel it.
- R8: An uncached store-exclusive (`req_uncached`=1) succeeds only if the processor's latest load-exclusive was also uncached to that word.
- R9: When several store-exclusives that would succeed target the same word in one cycle, the lowest processor number wins and the rest return 1. A plain store to the same word by another processor in that cycle makes them all fail. Among plain writes to the same byte, the lowest processor number lands.
- R10: After reset, no response is valid, no booking exists and every memory byte reads 0.
- R11: `rsp_valid` follows `req_valid` by one cycle. Status is 1 only for a failed store-exclusive. A read returns the value from before any write in the same cycle.
- R12: A load-exclusive books nothing if, in the same cycle, another processor commits a write to that word or its own clear or event pulse is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | N | Request strobe per processor |
| req_kind | input | 2*N | Request kind per processor (0 LD, 1 ST, 2 LDEX, 3 STEX) |
| req_addr | input | N*AW | Physical byte address per processor |
| req_wdata | input | 8*N | Write byte per processor |
| req_uncached | input | N | Access is to an uncached location |
| clr_excl | input | N | Clear-reservation command per processor |
| ctx_event | input | N | Interrupt or context-switch pulse per processor |
| rsp_valid | output | N | Response strobe, one cycle after the request |
| rsp_rdata | output | 8*N | Read byte (0 when no request) |
| rsp_status | output | N | 1 = store-exclusive refused |

## Verification
The assertions assume that inputs are never unknown after reset and that any request's kind and address are meaningful in the cycle its strobe is high. Clear and event pulses may coincide with requests freely. The bench drives every input to a defined value shortly after each rising edge, and its random phase confines addresses to a few words so that cancellations, same-cycle races and lost bookings happen often. A behavioural model of memory and bookings predicts every response in every cycle.

// File: rtl/excl_monitor.sv
module excl_monitor #(
  parameter int N  = 4,
  parameter int AW = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N-1:0]    req_valid,
  input  logic [2*N-1:0]  req_kind,
  input  logic [N*AW-1:0] req_addr,
  input  logic [8*N-1:0]  req_wdata,
  input  logic [N-1:0]    req_uncached,
  input  logic [N-1:0]    clr_excl,
  input  logic [N-1:0]    ctx_event,
  output logic [N-1:0]    rsp_valid,
  output logic [8*N-1:0]  rsp_rdata,
  output logic [N-1:0]    rsp_status
);
  localparam int DEPTH = 1 << AW;
  localparam int WA    = AW - 2;
  localparam logic [1:0] K_ST = 2'd1, K_LX = 2'd2, K_SX = 2'd3;

  logic [7:0]    mem [DEPTH];
  logic [N-1:0]  lv, gv, lv_n, gv_n;
  logic [WA-1:0] la [N], ga [N], la_n [N], ga_n [N];
  logic [AW-1:0] ad [N];
  logic [WA-1:0] wd [N];
  logic [N-1:0]  is_st, is_lx, is_sx, sx_ok, sx_win, wr, hit;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      ad[i]    = req_addr[AW*i +: AW];
      wd[i]    = ad[i][AW-1:2];
      is_st[i] = req_valid[i] && req_kind[2*i +: 2] == K_ST;
      is_lx[i] = req_valid[i] && req_kind[2*i +: 2] == K_LX;
      is_sx[i] = req_valid[i] && req_kind[2*i +: 2] == K_SX;
      sx_ok[i] = is_sx[i] && lv[i] && la[i] == wd[i] &&
                 (!req_uncached[i] || (gv[i] && ga[i] == wd[i]));
    end
    for (int i = 0; i < N; i++) begin
      sx_win[i] = sx_ok[i];
      for (int j = 0; j < N; j++)
        if (j != i && wd[j] == wd[i] && (is_st[j] || (j < i && sx_ok[j])))
          sx_win[i] = 1'b0;
    end
    wr = is_st | sx_win;
    for (int i = 0; i < N; i++) begin
      lv_n[i] = lv[i]; gv_n[i] = gv[i];
      la_n[i] = la[i]; ga_n[i] = ga[i];
      hit[i]  = 1'b0;
      for (int j = 0; j < N; j++)
        if (j != i && wr[j]) begin
          if (wd[j] == la[i]) lv_n[i] = 1'b0;
          if (wd[j] == ga[i]) gv_n[i] = 1'b0;
          if (wd[j] == wd[i]) hit[i]  = 1'b1;
        end
      if (clr_excl[i]) lv_n[i] = 1'b0;
      if (ctx_event[i] || is_sx[i] || is_lx[i]) begin
        lv_n[i] = 1'b0;
        gv_n[i] = 1'b0;
      end
      if (is_lx[i] && !hit[i] && !clr_excl[i] && !ctx_event[i]) begin
        lv_n[i] = 1'b1;
        la_n[i] = wd[i];
        gv_n[i] = req_uncached[i];
        ga_n[i] = wd[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lv <= '0;
      gv <= '0;
      rsp_valid  <= '0;
      rsp_rdata  <= '0;
      rsp_status <= '0;
      for (int i = 0; i < N; i++) begin
        la[i] <= '0;
        ga[i] <= '0;
      end
      for (int a = 0; a < DEPTH; a++) mem[a] <= '0;
    end else begin
      lv <= lv_n;
      gv <= gv_n;
      rsp_valid <= req_valid;
      for (int i = 0; i < N; i++) begin
        la[i] <= la_n[i];
        ga[i] <= ga_n[i];
        rsp_rdata[8*i +: 8] <= req_valid[i] ? mem[ad[i]] : 8'h00;
        rsp_status[i]       <= is_sx[i] && !sx_win[i];
      end
      for (int i = N - 1; i >= 0; i--)
        if (wr[i]) mem[ad[i]] <= req_wdata[8*i +: 8];
    end
  end
endmodule

// File: rtl/excl_monitor_chk.sv
module excl_monitor_chk #(
  parameter int N  = 4,
  parameter int AW = 6
) (
  input logic            clk,
  input logic            rst_n,
  input logic [N-1:0]    req_valid,
  input logic [2*N-1:0]  req_kind,
  input logic [N*AW-1:0] req_addr,
  input logic [N-1:0]    ctx_event,
  input logic [N-1:0]    rsp_valid,
  input logic [N-1:0]    rsp_status,
  input logic [N-1:0]    lv
);
  for (genvar i = 0; i < N; i++) begin : g_p
    assert_rsp_follows_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> rsp_valid[i] == $past(req_valid[i]));
    assert_status_only_sx_R11: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_status[i] |-> $past(req_valid[i] && req_kind[2*i +: 2] == 2'd3));
    assert_unbooked_fails_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid[i] && req_kind[2*i +: 2] == 2'd3 && !lv[i]) |=> rsp_status[i]);
    assert_event_fails_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ctx_event[i] ##1 (req_valid[i] && req_kind[2*i +: 2] == 2'd3)) |=> rsp_status[i]);
    for (genvar j = i + 1; j < N; j++) begin : g_q
      assert_single_winner_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid[i] && req_valid[j] && req_kind[2*i +: 2] == 2'd3 &&
         req_kind[2*j +: 2] == 2'd3 &&
         req_addr[AW*i+2 +: AW-2] == req_addr[AW*j+2 +: AW-2])
        |=> (rsp_status[i] || rsp_status[j]));
    end
  end
endmodule

bind excl_monitor excl_monitor_chk #(.N(N), .AW(AW)) chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
  .req_addr(req_addr), .ctx_event(ctx_event), .rsp_valid(rsp_valid),
  .rsp_status(rsp_status), .lv(lv));

// File: tb/excl_monitor_test.sv
module excl_monitor_test;
  localparam int N = 4, AW = 6, DEPTH = 64;
  logic clk = 0, rst_n = 0;
  always #4 clk = ~clk;

  logic [N-1:0] req_valid, req_uncached, clr_excl, ctx_event, rsp_valid, rsp_status;
  logic [2*N-1:0] req_kind;
  logic [N*AW-1:0] req_addr;
  logic [8*N-1:0] req_wdata, rsp_rdata;

  int v[N], k[N], a[N], d[N], nc[N], cl[N], ev[N];
  int mm[DEPTH], lr[N], gr[N];
  int ev_v[N], ev_d[N], ev_s[N];
  int total = 0, bad = 0;

  always_comb
    for (int i = 0; i < N; i++) begin
      req_valid[i] = v[i][0]; req_kind[2*i +: 2] = k[i][1:0];
      req_addr[AW*i +: AW] = a[i][AW-1:0]; req_wdata[8*i +: 8] = d[i][7:0];
      req_uncached[i] = nc[i][0]; clr_excl[i] = cl[i][0]; ctx_event[i] = ev[i][0];
    end

  excl_monitor #(.N(N), .AW(AW)) uut (.*);

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic idle();
    for (int i = 0; i < N; i++) begin
      v[i] = 0; k[i] = 0; a[i] = 0; d[i] = 0; nc[i] = 0; cl[i] = 0; ev[i] = 0;
    end
  endtask

  task automatic model();
    int w[N]; bit ok[N], win[N], wrt[N], hit[N];
    for (int i = 0; i < N; i++) begin
      w[i] = a[i] / 4;
      ev_v[i] = v[i];
      ev_d[i] = v[i] ? mm[a[i]] : 0;
      ok[i] = v[i] && k[i] == 3 && lr[i] == w[i] && (!nc[i] || gr[i] == w[i]);
    end
    for (int i = 0; i < N; i++) begin
      win[i] = ok[i];
      for (int j = 0; j < N; j++)
        if (j != i && w[j] == w[i] && ((v[j] && k[j] == 1) || (j < i && ok[j]))) win[i] = 0;
      wrt[i] = (v[i] && k[i] == 1) || win[i];
      ev_s[i] = v[i] && k[i] == 3 && !win[i];
    end
    for (int i = 0; i < N; i++) begin
      hit[i] = 0;
      for (int j = 0; j < N; j++)
        if (j != i && wrt[j]) begin
          if (lr[i] == w[j]) lr[i] = -1;
          if (gr[i] == w[j]) gr[i] = -1;
          if (w[j] == w[i]) hit[i] = 1;
        end
      if (cl[i]) lr[i] = -1;
      if (ev[i] || (v[i] && k[i] >= 2)) begin lr[i] = -1; gr[i] = -1; end
      if (v[i] && k[i] == 2 && !hit[i] && !cl[i] && !ev[i]) begin
        lr[i] = w[i]; gr[i] = nc[i] ? w[i] : -1;
      end
    end
    for (int i = N - 1; i >= 0; i--) if (wrt[i]) mm[a[i]] = d[i];
  endtask

  task automatic step(string tag);
    model();
    @(posedge clk); #2;
    for (int i = 0; i < N; i++) begin
      chk({tag, " valid"}, int'(rsp_valid[i]), ev_v[i]);
      chk({tag, " data"}, int'(rsp_rdata[8*i +: 8]), ev_d[i]);
      chk({tag, " status"}, int'(rsp_status[i]), ev_s[i]);
    end
    idle();
  endtask

  task automatic rq(int p, int kind, int addr, int data, int unc);
    v[p] = 1; k[p] = kind; a[p] = addr; d[p] = data; nc[p] = unc;
  endtask

  initial begin
    #(8 * 200000);
    bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle();
    for (int i = 0; i < DEPTH; i++) mm[i] = 0;
    for (int i = 0; i < N; i++) begin lr[i] = -1; gr[i] = -1; end
    repeat (3) @(posedge clk);
    #2;
    chk("R10 rsp_valid", int'(rsp_valid), 0);
    chk("R10 rsp_status", int'(rsp_status), 0);
    rst_n = 1;
    rq(0, 0, 9, 0, 0); rq(1, 0, 40, 0, 0); step("R10 zero mem");
    chk("R10 read zero", int'(rsp_rdata[15:8]), 0);
    // R1 / R2
    rq(0, 1, 5, 8'hAA, 0); step("R1 setup");
    rq(0, 2, 5, 0, 0); step("R1 ldex");
    chk("R1 ldex data", int'(rsp_rdata[7:0]), 8'hAA);
    rq(0, 3, 6, 8'h11, 0); step("R2 stex");
    chk("R2 stex status", int'(rsp_status[0]), 0);
    rq(0, 0, 6, 0, 0); step("R2 readback");
    chk("R2 written", int'(rsp_rdata[7:0]), 8'h11);
    // R3
    rq(1, 3, 8, 8'h77, 0); step("R3 stex unbooked");
    chk("R3 status", int'(rsp_status[1]), 1);
    rq(1, 0, 8, 0, 0); step("R3 readback");
    chk("R3 memory kept", int'(rsp_rdata[15:8]), 0);
    // R4
    rq(1, 2, 8, 0, 0); step("R4 ldex");
    rq(1, 3, 8, 8'h21, 0); step("R4 first");
    chk("R4 first ok", int'(rsp_status[1]), 0);
    rq(1, 3, 8, 8'h22, 0); step("R4 second");
    chk("R4 second fails", int'(rsp_status[1]), 1);
    // R5
    rq(2, 2, 12, 0, 0); step("R5 ldex");
    cl[2] = 1; step("R5 clear");
    chk("R5 no access", int'(rsp_valid[2]), 0);
    rq(2, 3, 12, 8'h33, 0); step("R5 stex");
    chk("R5 fails", int'(rsp_status[2]), 1);
    // R6
    rq(2, 2, 12, 0, 0); step("R6 ldex");
    ev[2] = 1; step("R6 event");
    rq(2, 3, 12, 8'h34, 0); step("R6 stex");
    chk("R6 fails", int'(rsp_status[2]), 1);
    // R7
    rq(0, 2, 16, 0, 0); step("R7 ldex");
    rq(1, 1, 17, 8'h44, 0); step("R7 other store");
    rq(0, 3, 16, 8'h45, 0); step("R7 stex");
    chk("R7 other cancels", int'(rsp_status[0]), 1);
    rq(0, 2, 16, 0, 0); step("R7 ldex own");
    rq(0, 1, 16, 8'h46, 0); step("R7 own store");
    rq(0, 3, 16, 8'h47, 0); step("R7 stex own");
    chk("R7 own keeps", int'(rsp_status[0]), 0);
    // R8
    rq(3, 2, 20, 0, 0); step("R8 cached ldex");
    rq(3, 3, 20, 8'h55, 1); step("R8 uncached stex");
    chk("R8 needs global", int'(rsp_status[3]), 1);
    rq(3, 2, 20, 0, 1); step("R8 uncached ldex");
    rq(3, 3, 21, 8'h56, 1); step("R8 uncached stex2");
    chk("R8 global ok", int'(rsp_status[3]), 0);
    // R9
    rq(0, 2, 24, 0, 0); rq(1, 2, 25, 0, 0); step("R9 ldex both");
    rq(0, 3, 24, 8'h61, 0); rq(1, 3, 25, 8'h62, 0); step("R9 race");
    chk("R9 low wins", int'(rsp_status[0]), 0);
    chk("R9 high loses", int'(rsp_status[1]), 1);
    rq(2, 0, 24, 0, 0); rq(3, 0, 25, 0, 0); step("R9 readback");
    chk("R9 winner data", int'(rsp_rdata[23:16]), 8'h61);
    chk("R9 loser no write", int'(rsp_rdata[31:24]), 0);
    // R12
    rq(1, 1, 28, 8'h71, 0); rq(2, 2, 29, 0, 0); step("R12 same-cycle write");
    rq(2, 3, 29, 8'h72, 0); step("R12 stex");
    chk("R12 no booking", int'(rsp_status[2]), 1);
    rq(3, 2, 30, 0, 0); cl[3] = 1; step("R12 ldex with clear");
    rq(3, 3, 30, 8'h73, 0); step("R12 stex2");
    chk("R12 clear wins", int'(rsp_status[3]), 1);
    // R11
    rq(0, 1, 32, 8'h55, 0); rq(1, 0, 32, 0, 0); step("R11 read before write");
    chk("R11 old value", int'(rsp_rdata[15:8]), 0);
    for (int c = 0; c < 4000; c++) begin
      for (int i = 0; i < N; i++) begin
        v[i] = ($urandom % 3) != 0; k[i] = $urandom % 4; a[i] = $urandom % 12;
        d[i] = $urandom % 256; nc[i] = $urandom % 2;
        cl[i] = ($urandom % 16) == 0; ev[i] = ($urandom % 16) == 0;
      end
      step("R11 random");
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule